// File: doc/BRIEF.md
# Segment Register Descriptor Loader

This block keeps six segment registers. Each register pairs a 16-bit visible selector with a hidden cached copy of the descriptor that the selector names. When software writes a selector, the block splits it into its fields and picks the local or the global descriptor table. It then reads the 8-byte descriptor as two 32-bit words over a plain memory read port. If the descriptor passes its checks, the block refreshes the hidden cache of that register. A bad load raises a fault with a code, and the register keeps its previous contents.

Register numbers 0 and 1 hold the code and stack segments. Numbers 2 to 5 are data segment registers. A controller with five states sequences each load. ST_IDLE goes to ST_CHECK when a selector write is accepted. ST_CHECK returns to ST_IDLE on a null selector or a table-limit fault, and otherwise goes to ST_RD_LO. ST_RD_LO goes to ST_RD_HI on the first read acknowledge. ST_RD_HI goes to ST_EVAL on the second acknowledge. ST_EVAL always returns to ST_IDLE, either committing the descriptor or raising a not-present fault. A combinational read port shows the contents of any register to the logic that uses the segments.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, every register reads selector 0 with all cached fields 0 and usable 0, and busy is 0.
- R2: Selector bits [1:0] are the requestor privilege level, bit [2] selects the table (0 local, 1 global), and bits [15:3] are the index. The low descriptor word is read from table base + index*8 and the high word from that address + 4.
- R3: The low word holds limit[15:0] in [15:0] and base[15:0] in [31:16]. The high word holds base[23:16] in [7:0], type in [11:8], S in [12], DPL in [14:13], present in [15], limit[19:16] in [19:16], D/B in [22], G in [23] and base[31:24] in [31:24]. A successful load copies all of these fields into the cache.
- R4: If the fetched descriptor has present = 0, fault pulses with fault_code 2 and the target register is left unchanged.
- R5: An index greater than the selected table's maximum index raises fault with code 1, and no memory read is issued. An index equal to the maximum loads normally.
- R6: A null selector (index 0, table bit 0, any privilege level) written to registers 2..5 completes with no memory read and leaves the register with that selector, zero fields and usable 0. Written to register 0 or 1, it faults with code 3 and the register is unchanged. Global index 0 is not null.
- R7: busy is 1 from the cycle after an accepted write through the cycle in which done or fault pulses, and is 0 the cycle after. No read is requested while busy is 0.
- R8: A selector write while busy is ignored and pulses overlap in the same cycle. A write naming a register number above 5 is ignored.
- R9: Every accepted write produces exactly one one-cycle pulse of done or fault, never both.
- R10: A successful load sets usable to 1 and keeps the written selector, including its privilege level, in the register.
- R11: While a read is requested and not yet acknowledged, the request stays high with a stable address. Any number of wait cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_wr_reg | input | 3 | Target register number |
| sel_wr_val | input | 16 | Selector value written |
| ldt_base | input | 32 | Local table base address |
| ldt_max_idx | input | 13 | Highest valid local index |
| gdt_base | input | 32 | Global table base address |
| gdt_max_idx | input | 13 | Highest valid global index |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data word |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed pulse |
| fault | output | 1 | Load rejected pulse |
| fault_code | output | 2 | 1 table limit, 2 not present, 3 null into code/stack |
| overlap | output | 1 | Write ignored because busy |
| rd_idx | input | 3 | Register to show on the read port |
| rd_sel | output | 16 | Visible selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 20 | Cached limit |
| rd_gran | output | 1 | Cached granularity |
| rd_db | output | 1 | Cached D/B |
| rd_sys | output | 1 | Cached S bit |
| rd_dpl | output | 2 | Cached descriptor privilege |
| rd_type | output | 4 | Cached type |
| rd_present | output | 1 | Cached present bit |
| rd_usable | output | 1 | Register holds a valid descriptor |

## Verification
A new selector write can arrive in the same cycle that an earlier load finishes. In that cycle the cache is committed while the incoming write is being refused. The bench provokes this by watching for the done or fault pulse and presenting a second write in exactly that cycle. The overlap pulse must appear, busy must fall in the next cycle with no second result ever reported, and the target of the refused write must read back unchanged. The same refusal is also tested in the middle of a fetch that has memory wait cycles.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef struct packed {
        logic [15:0] sel;
        logic [31:0] base;
        logic [19:0] limit;
        logic        gran;
        logic        db;
        logic        sys;
        logic [1:0]  dpl;
        logic [3:0]  typ;
        logic        present;
        logic        usable;
    } seg_entry_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_LIMIT  = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_NULL   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_LO,
        ST_RD_HI,
        ST_EVAL
    } ld_state_e;

    // Assemble a cache entry from the two descriptor words.
    function automatic seg_entry_t unpack_desc(input logic [15:0] sel,
                                               input logic [31:0] lo,
                                               input logic [31:0] hi);
        seg_entry_t e;
        e.sel     = sel;
        e.base    = {hi[31:24], hi[7:0], lo[31:16]};
        e.limit   = {hi[19:16], lo[15:0]};
        e.gran    = hi[23];
        e.db      = hi[22];
        e.sys     = hi[12];
        e.dpl     = hi[14:13];
        e.typ     = hi[11:8];
        e.present = hi[15];
        e.usable  = hi[15];
        return e;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [SEL_W-4:0]  ldt_max_idx,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [SEL_W-4:0]  gdt_max_idx,
    output logic              is_null,
    output logic              over_limit,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int IDX_W = SEL_W - 3;
    localparam int PAD_W = ADDR_W - IDX_W - 3;

    logic [IDX_W-1:0] idx;
    logic             use_global;

    always_comb begin
        idx        = sel[SEL_W-1:3];
        use_global = sel[2];
        is_null    = (idx == '0) && !use_global;
        over_limit = use_global ? (idx > gdt_max_idx) : (idx > ldt_max_idx);
        desc_addr  = (use_global ? gdt_base : ldt_base)
                   + {{PAD_W{1'b0}}, idx, 3'b000};
    end
endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
    import seg_pkg::*;
#(
    parameter int NUM_SEG    = 6,
    parameter int FIRST_DATA = 2,
    parameter int SEL_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int RID_W      = $clog2(NUM_SEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [RID_W-1:0]  sel_wr_reg,
    input  logic [SEL_W-1:0]  sel_wr_val,
    input  logic              is_null,
    input  logic              over_limit,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic              mem_rd_ack,
    input  logic [31:0]       mem_rd_data,
    output logic [SEL_W-1:0]  req_sel,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output fault_e            fault_code,
    output logic              overlap,
    output logic              cw_en,
    output logic [RID_W-1:0]  cw_idx,
    output seg_entry_t        cw_entry
);
    localparam logic [RID_W-1:0] NUM_ID   = RID_W'(NUM_SEG);
    localparam logic [RID_W-1:0] FIRST_ID = RID_W'(FIRST_DATA);

    ld_state_e        state, nxt;
    logic [RID_W-1:0] req_reg;
    logic [31:0]      lo_q, hi_q;
    logic             accept;
    seg_entry_t       desc_v;

    assign accept = sel_wr && (state == ST_IDLE) && (sel_wr_reg < NUM_ID);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request and descriptor word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sel <= '0;
            req_reg <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            if (accept) begin
                req_sel <= sel_wr_val;
                req_reg <= sel_wr_reg;
            end
            if (state == ST_RD_LO && mem_rd_ack) lo_q <= mem_rd_data;
            if (state == ST_RD_HI && mem_rd_ack) hi_q <= mem_rd_data;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_CHECK;
            ST_CHECK: nxt = (is_null || over_limit) ? ST_IDLE : ST_RD_LO;
            ST_RD_LO: if (mem_rd_ack) nxt = ST_RD_HI;
            ST_RD_HI: if (mem_rd_ack) nxt = ST_EVAL;
            ST_EVAL:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        desc_v      = unpack_desc(req_sel, lo_q, hi_q);
        busy        = (state != ST_IDLE);
        overlap     = sel_wr && busy;
        mem_rd_req  = 1'b0;
        mem_rd_addr = desc_addr;
        done        = 1'b0;
        fault       = 1'b0;
        fault_code  = FLT_NONE;
        cw_en       = 1'b0;
        cw_idx      = req_reg;
        cw_entry    = '0;
        unique case (state)
            ST_IDLE: ;
            ST_CHECK: begin
                if (is_null) begin
                    if (req_reg >= FIRST_ID) begin
                        done         = 1'b1;
                        cw_en        = 1'b1;
                        cw_entry.sel = req_sel;
                    end else begin
                        fault      = 1'b1;
                        fault_code = FLT_NULL;
                    end
                end else if (over_limit) begin
                    fault      = 1'b1;
                    fault_code = FLT_LIMIT;
                end
            end
            ST_RD_LO: mem_rd_req = 1'b1;
            ST_RD_HI: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = desc_addr + ADDR_W'(4);
            end
            ST_EVAL: begin
                cw_entry = desc_v;
                if (desc_v.present) begin
                    done  = 1'b1;
                    cw_en = 1'b1;
                end else begin
                    fault      = 1'b1;
                    fault_code = FLT_ABSENT;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int RID_W   = $clog2(NUM_SEG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_en,
    input  logic [RID_W-1:0] cw_idx,
    input  seg_entry_t       cw_entry,
    input  logic [RID_W-1:0] rd_idx,
    output seg_entry_t       rd_entry
);
    localparam logic [RID_W-1:0] NUM_ID = RID_W'(NUM_SEG);

    seg_entry_t ent [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (cw_en && cw_idx == RID_W'(g))
                ent[g] <= cw_entry;
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM_SEG; i++)
            if (rd_idx == RID_W'(i)) rd_entry = ent[i];
        if (rd_idx >= NUM_ID) rd_entry = '0;
    end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_pkg::*;
#(
    parameter int NUM_SEG    = 6,
    parameter int FIRST_DATA = 2,
    parameter int SEL_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int RID_W      = $clog2(NUM_SEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [RID_W-1:0]  sel_wr_reg,
    input  logic [SEL_W-1:0]  sel_wr_val,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [SEL_W-4:0]  ldt_max_idx,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [SEL_W-4:0]  gdt_max_idx,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [31:0]       mem_rd_data,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic              overlap,
    input  logic [RID_W-1:0]  rd_idx,
    output logic [15:0]       rd_sel,
    output logic [31:0]       rd_base,
    output logic [19:0]       rd_limit,
    output logic              rd_gran,
    output logic              rd_db,
    output logic              rd_sys,
    output logic [1:0]        rd_dpl,
    output logic [3:0]        rd_type,
    output logic              rd_present,
    output logic              rd_usable
);
    logic [SEL_W-1:0]  req_sel;
    logic              is_null, over_limit;
    logic [ADDR_W-1:0] desc_addr;
    logic              cw_en;
    logic [RID_W-1:0]  cw_idx;
    seg_entry_t        cw_entry, rd_entry;
    fault_e            flt;

    seg_sel_decode #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dec (
        .sel         (req_sel),
        .ldt_base    (ldt_base),
        .ldt_max_idx (ldt_max_idx),
        .gdt_base    (gdt_base),
        .gdt_max_idx (gdt_max_idx),
        .is_null     (is_null),
        .over_limit  (over_limit),
        .desc_addr   (desc_addr)
    );

    seg_load_fsm #(
        .NUM_SEG(NUM_SEG), .FIRST_DATA(FIRST_DATA),
        .SEL_W(SEL_W), .ADDR_W(ADDR_W), .RID_W(RID_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr      (sel_wr),
        .sel_wr_reg  (sel_wr_reg),
        .sel_wr_val  (sel_wr_val),
        .is_null     (is_null),
        .over_limit  (over_limit),
        .desc_addr   (desc_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .req_sel     (req_sel),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .busy        (busy),
        .done        (done),
        .fault       (fault),
        .fault_code  (flt),
        .overlap     (overlap),
        .cw_en       (cw_en),
        .cw_idx      (cw_idx),
        .cw_entry    (cw_entry)
    );

    seg_cache_bank #(.NUM_SEG(NUM_SEG), .RID_W(RID_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_en    (cw_en),
        .cw_idx   (cw_idx),
        .cw_entry (cw_entry),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    assign fault_code = flt;
    assign rd_sel     = rd_entry.sel;
    assign rd_base    = rd_entry.base;
    assign rd_limit   = rd_entry.limit;
    assign rd_gran    = rd_entry.gran;
    assign rd_db      = rd_entry.db;
    assign rd_sys     = rd_entry.sys;
    assign rd_dpl     = rd_entry.dpl;
    assign rd_type    = rd_entry.typ;
    assign rd_present = rd_entry.present;
    assign rd_usable  = rd_entry.usable;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [1:0]        fault_code,
    input logic              mem_rd_req,
    input logic              mem_rd_ack,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              rd_usable,
    input logic              rd_present
);
    p_result_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> busy);

    p_idle_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req);

    p_single_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_free_after_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);

    p_fault_has_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 2'd0));

    p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    p_usable_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_usable |-> rd_present);
endmodule

bind seg_load_unit seg_load_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .fault_code  (fault_code),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_addr (mem_rd_addr),
    .rd_usable   (rd_usable),
    .rd_present  (rd_present)
);

// File: tb/sim_seg_load_unit.sv
module sim_seg_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [2:0]  sel_wr_reg = '0;
    logic [15:0] sel_wr_val = '0;
    logic [31:0] ldt_base = 32'h0001_0000;
    logic [12:0] ldt_max_idx = 13'd7;
    logic [31:0] gdt_base = 32'h0008_0000;
    logic [12:0] gdt_max_idx = 13'd31;
    logic        mem_rd_req, mem_rd_ack;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic        busy, done, fault, overlap;
    logic [1:0]  fault_code;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_sel;
    logic [31:0] rd_base;
    logic [19:0] rd_limit;
    logic        rd_gran, rd_db, rd_sys, rd_present, rd_usable;
    logic [1:0]  rd_dpl;
    logic [3:0]  rd_type;

    int errors = 0;
    int checks = 0;
    int wait_n = 0;
    int wcnt = 0;
    int acks = 0;

    logic [31:0] mem_q [logic [31:0]];

    typedef struct {
        int          r;
        bit          isf;
        int          code;
        logic [15:0] sel;
        logic [31:0] base;
        logic [19:0] lim;
        logic [9:0]  attr;
        bit          use_ok;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] m_sel  [6];
    logic [31:0] m_base [6];
    logic [19:0] m_lim  [6];
    logic [9:0]  m_attr [6];
    bit          m_use  [6];

    always #2 clk = ~clk;

    seg_load_unit u0 (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wr_reg(sel_wr_reg),
        .sel_wr_val(sel_wr_val), .ldt_base(ldt_base), .ldt_max_idx(ldt_max_idx),
        .gdt_base(gdt_base), .gdt_max_idx(gdt_max_idx),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .overlap(overlap), .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_base(rd_base),
        .rd_limit(rd_limit), .rd_gran(rd_gran), .rd_db(rd_db), .rd_sys(rd_sys),
        .rd_dpl(rd_dpl), .rd_type(rd_type), .rd_present(rd_present),
        .rd_usable(rd_usable)
    );

    // Memory model with programmable wait cycles (R11)
    assign mem_rd_ack = mem_rd_req && (wcnt >= wait_n);
    always_comb mem_rd_data = mem_q.exists(mem_rd_addr) ? mem_q[mem_rd_addr] : 32'h0;
    always @(posedge clk) begin
        if (mem_rd_req && !mem_rd_ack) wcnt <= wcnt + 1;
        else                           wcnt <= 0;
        if (mem_rd_req && mem_rd_ack)  acks <= acks + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_reg(input int r, input string tag);
        logic [9:0] a;
        rd_idx = 3'(r);
        #1;
        a = {rd_gran, rd_db, rd_sys, rd_dpl, rd_type, rd_present};
        check(rd_sel == m_sel[r], tag, "selector", 64'(rd_sel), 64'(m_sel[r]));
        check(rd_base == m_base[r], tag, "base", 64'(rd_base), 64'(m_base[r]));
        check(rd_limit == m_lim[r], tag, "limit", 64'(rd_limit), 64'(m_lim[r]));
        check(a == m_attr[r], tag, "attributes", 64'(a), 64'(m_attr[r]));
        check(rd_usable == m_use[r], tag, "usable", 64'(rd_usable), 64'(m_use[r]));
    endtask

    // Monitor: pop expected result and compare outcome and register contents
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (done || fault)) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected result", 64'({done, fault}), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(fault == e.isf, "R9", "result kind", 64'(fault), 64'(e.isf));
                    if (e.isf)
                        check(fault_code == 2'(e.code), "R5", "fault code",
                              64'(fault_code), 64'(e.code));
                    else begin
                        m_sel[e.r] = e.sel;   m_base[e.r] = e.base;
                        m_lim[e.r] = e.lim;   m_attr[e.r] = e.attr;
                        m_use[e.r] = e.use_ok;
                    end
                    @(negedge clk);
                    cmp_reg(e.r, e.isf ? "R4" : "R3");
                end
            end
        end
    end

    function automatic logic [31:0] hi_word(input logic [31:0] b, input logic [19:0] l,
                                            input bit g, input bit db, input bit s,
                                            input logic [1:0] dpl, input logic [3:0] t,
                                            input bit p);
        return {b[31:24], g, db, 2'b00, l[19:16], p, dpl, s, t, b[23:16]};
    endfunction

    // Driver: present one selector write and wait for the load to settle (R7)
    task automatic do_write(input int r, input logic [15:0] sel);
        @(negedge clk);
        sel_wr = 1'b1; sel_wr_reg = 3'(r); sel_wr_val = sel;
        @(negedge clk);
        sel_wr = 1'b0;
        check(busy == 1'b1, "R7", "busy after write", 64'(busy), 64'd1);
        while (busy) @(negedge clk);
        check(busy == 1'b0, "R7", "busy after result", 64'(busy), 64'd0);
        @(negedge clk);
    endtask

    task automatic push_ok(input int r, input logic [15:0] sel, input logic [31:0] b,
                           input logic [19:0] l, input bit g, input bit db, input bit s,
                           input logic [1:0] dpl, input logic [3:0] t);
        exp_t e;
        logic [31:0] a;
        a = (sel[2] ? gdt_base : ldt_base) + {16'h0, sel[15:3], 3'b000};
        mem_q[a]     = {b[15:0], l[15:0]};
        mem_q[a + 4] = hi_word(b, l, g, db, s, dpl, t, 1'b1);
        e = '{r: r, isf: 0, code: 0, sel: sel, base: b, lim: l,
              attr: {g, db, s, dpl, t, 1'b1}, use_ok: 1};
        sb.push_back(e);
    endtask

    task automatic push_fault(input int r, input int code);
        exp_t e;
        e = '{r: r, isf: 1, code: code, sel: 0, base: 0, lim: 0, attr: 0, use_ok: 0};
        sb.push_back(e);
    endtask

    task automatic push_null(input int r, input logic [15:0] sel);
        exp_t e;
        e = '{r: r, isf: 0, code: 0, sel: sel, base: 0, lim: 0, attr: 0, use_ok: 0};
        sb.push_back(e);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int a0;
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_attr[i] = '0; m_use[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy at reset", 64'(busy), 64'd0);
        for (int i = 0; i < 6; i++) cmp_reg(i, "R1");

        // R2 R3 R10: global table, code register, privilege level 0
        push_ok(0, 16'h002C, 32'h1234_5678, 20'hABCDE, 1, 1, 1, 2'd2, 4'hA);
        do_write(0, 16'h002C);

        // R2 R11: local table with wait cycles, privilege level 3
        wait_n = 2;
        push_ok(2, 16'h001B, 32'h00AB_CDEF, 20'h0FFFF, 0, 0, 1, 2'd3, 4'h2);
        do_write(2, 16'h001B);
        wait_n = 0;

        // R4: not-present descriptor, register 3 unchanged
        begin
            logic [31:0] a;
            a = gdt_base + 32'd72;
            mem_q[a] = 32'hFFFF_FFFF;
            mem_q[a + 4] = hi_word(32'hFFFF_FFFF, 20'hFFFFF, 1, 1, 1, 2'd3, 4'hF, 1'b0);
        end
        push_fault(3, 2);
        do_write(3, 16'h004C);

        // R5: index above local maximum, no memory read
        a0 = acks;
        push_fault(4, 1);
        do_write(4, 16'h0040);
        check(acks == a0, "R5", "reads on limit fault", 64'(acks - a0), 64'd0);

        // R5: index equal to maximum loads, local and global
        push_ok(4, 16'h003A, 32'hCAFE_0000, 20'h00123, 0, 1, 0, 2'd1, 4'h5);
        do_write(4, 16'h003A);
        push_ok(1, 16'h00FD, 32'h0000_1000, 20'hFFFFF, 1, 1, 1, 2'd0, 4'h3);
        do_write(1, 16'h00FD);

        // R6: null into a data register, no read
        a0 = acks;
        push_null(5, 16'h0003);
        do_write(5, 16'h0003);
        check(acks == a0, "R6", "reads on null load", 64'(acks - a0), 64'd0);
        // R6: null into stack and code registers faults
        push_fault(1, 3);
        do_write(1, 16'h0000);
        push_fault(0, 3);
        do_write(0, 16'h0001);
        // R6: global index 0 is not null, empty memory reads as absent
        a0 = acks;
        push_fault(2, 2);
        do_write(2, 16'h0004);
        check(acks == a0 + 2, "R6", "reads on global index 0", 64'(acks - a0), 64'd2);

        // R8: write while fetching with wait cycles is ignored
        wait_n = 3;
        push_ok(2, 16'h0011, 32'h5555_AAAA, 20'h54321, 1, 0, 0, 2'd2, 4'h9);
        @(negedge clk);
        sel_wr = 1'b1; sel_wr_reg = 3'd2; sel_wr_val = 16'h0011;
        @(negedge clk);
        sel_wr_reg = 3'd5; sel_wr_val = 16'h000A;
        #1;
        check(overlap == 1'b1, "R8", "overlap mid-fetch", 64'(overlap), 64'd1);
        @(negedge clk);
        sel_wr = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        cmp_reg(5, "R8");
        wait_n = 0;

        // R8 R9: write in the same cycle as the result pulse
        push_ok(3, 16'h0024, 32'h0BAD_F00D, 20'h00FFF, 0, 1, 1, 2'd0, 4'hB);
        @(negedge clk);
        sel_wr = 1'b1; sel_wr_reg = 3'd3; sel_wr_val = 16'h0024;
        @(negedge clk);
        sel_wr_reg = 3'd4; sel_wr_val = 16'h003A;
        while (!(done || fault)) @(negedge clk);
        #1;
        check(overlap == 1'b1, "R8", "overlap at result cycle", 64'(overlap), 64'd1);
        @(negedge clk);
        sel_wr = 1'b0;
        check(busy == 1'b0, "R8", "busy after refused write", 64'(busy), 64'd0);
        @(negedge clk);
        cmp_reg(4, "R8");

        // R8: register number above 5 is ignored
        @(negedge clk);
        sel_wr = 1'b1; sel_wr_reg = 3'd6; sel_wr_val = 16'h002C;
        @(negedge clk);
        sel_wr = 1'b0;
        check(busy == 1'b0, "R8", "busy for register 6", 64'(busy), 64'd0);
        repeat (4) @(negedge clk);

        check(sb.size() == 0, "R9", "results outstanding", 64'(sb.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule